// File: doc/BRIEF.md
# Prioritized Nested Interrupt Controller

This block gathers up to 96 level-sensitive interrupt request lines, records each as pending, and offers the most urgent enabled pending request to a processor as an interrupt request together with its number and priority. Software programs it through a small word-addressed register port: one bank of words turns enables on, another turns them off, and a bank of byte-lane priority fields assigns one of 16 urgency levels to each line.

The processor accepts the offered request with an acknowledge pulse, which clears its pending bit and raises the running level to that request's priority. While a handler runs, only a strictly more urgent request is offered, so handlers nest. A completion pulse drops back to the level that was running before. Saved levels sit on a stack managed by a three-state machine: `ST_IDLE` (nothing running), `ST_NESTED` (one or more handlers running, room left) and `ST_FULL` (every stack slot used). Transitions: `ST_IDLE` to `ST_NESTED` on an accepted acknowledge; `ST_NESTED` to `ST_FULL` on an acknowledge that fills the last slot; `ST_NESTED` to `ST_IDLE` on a completion that empties the stack; `ST_FULL` to `ST_NESTED` on any completion. All other input combinations hold the state.

Top module: `prio_intc`

## Requirements
- R1: An input line that is high at a rising clock edge makes that interrupt pending from the next cycle on; it stays pending after the line drops and is cleared by the clock edge at which that interrupt is acknowledged.
- R2: Writing word k of the enable-on bank (byte address 0x100 + 4k) sets the enable of interrupt 32k+b for every bit b written as 1; bits written as 0 change nothing.
- R3: Writing word k of the enable-off bank (byte address 0x180 + 4k) clears the enable of interrupt 32k+b for every bit b written as 1; bits written as 0 change nothing. Reading word k of either bank returns the current enables of interrupts 32k..32k+31 (bit b for interrupt 32k+b).
- R4: Interrupt n has its priority in the register at byte address 0x400 + 4*(n/4), byte lane n%4, in bits [8*(n%4)+7 : 8*(n%4)+4]; the lower four bits of every lane read as zero and ignore writes.
- R5: The request output is high when some enabled pending interrupt has a priority value numerically below the running level; the offered number is the one with the smallest priority value, and among equal values the smallest interrupt number. A lower value is more urgent.
- R6: A pending interrupt whose enable is off is never offered and stays pending; it is offered once enabled.
- R7: An acknowledge while the request is high sets the running level to the offered priority at that edge and saves the previous level.
- R8: While a handler runs, a pending request of equal or less urgent priority is held back, and a strictly more urgent one is offered (preemption).
- R9: A completion restores the level saved by the matching acknowledge; a completion while idle has no effect; when acknowledge and completion coincide with a request offered, the acknowledge is taken and the completion is dropped.
- R10: After reset all enables and priorities are zero, nothing is pending, the request is low and the running level reads 16 (idle).
- R11: Addresses outside the three banks read as zero and writes to them change no state; nesting holds at least 16 levels deep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 96 | Level-sensitive request lines |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_req | output | 1 | An interrupt is offered to the processor |
| irq_id | output | 7 | Number of the offered interrupt |
| irq_prio | output | 4 | Priority of the offered interrupt |
| active_level | output | 5 | Running level, 16 when idle |
| irq_ack | input | 1 | Processor takes the offered interrupt |
| irq_done | input | 1 | Processor finishes the current handler |

## Verification
Register access is swept over every interrupt number: each enable bit is set and cleared alone, which separates word index from bit position and the two banks from each other, and every priority lane is written with a distinct value and all-ones low bits, which exposes lane swaps and leaking low bits. Arbitration is driven with several multi-line pending patterns over a priority table full of ties, draining each one acknowledge by acknowledge so that the expected order, computed in the bench, distinguishes ordering by value from ordering by number. Preemption is tried with an equal-priority and a more urgent arrival during a handler, a full 16-deep nest unwinds level by level, and the coincident acknowledge/completion and idle completion cases are applied on their own.

// File: rtl/intc_pkg.sv
package intc_pkg;

    // States of the nesting stack controller.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_NESTED = 2'd1,
        ST_FULL   = 2'd2
    } nest_state_e;

    localparam int unsigned SETEN_BASE = 32'h100;
    localparam int unsigned CLREN_BASE = 32'h180;
    localparam int unsigned PRIO_BASE  = 32'h400;

endpackage

// File: rtl/intc_regs.sv
module intc_regs #(
    parameter int N_IRQ     = 96,
    parameter int PRIO_BITS = 4,
    parameter int ADDR_W    = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [31:0]                bus_wdata,
    input  logic                       bus_we,
    output logic [31:0]                bus_rdata,
    output logic [N_IRQ-1:0]           en_vec,
    output logic [N_IRQ*PRIO_BITS-1:0] prio_flat
);
    import intc_pkg::*;

    localparam int N_EN_WORDS  = (N_IRQ + 31) / 32;
    localparam int N_PRIO_REGS = (N_IRQ + 3) / 4;
    localparam int LANE_LO     = 8 - PRIO_BITS;

    logic [N_EN_WORDS-1:0]    set_hit;
    logic [N_EN_WORDS-1:0]    clr_hit;
    logic [N_PRIO_REGS-1:0]   prio_hit;
    logic [N_EN_WORDS*32-1:0] en_pad;
    logic [N_PRIO_REGS*32-1:0] prio_pad;

    // Address decode, shared by reads and writes.
    always_comb begin
        set_hit  = '0;
        clr_hit  = '0;
        prio_hit = '0;
        for (int k = 0; k < N_EN_WORDS; k++) begin
            set_hit[k] = (bus_addr == ADDR_W'(SETEN_BASE + 4 * k));
            clr_hit[k] = (bus_addr == ADDR_W'(CLREN_BASE + 4 * k));
        end
        for (int j = 0; j < N_PRIO_REGS; j++) begin
            prio_hit[j] = (bus_addr == ADDR_W'(PRIO_BASE + 4 * j));
        end
    end

    // One enable flop and one priority field per interrupt.
    for (genvar n = 0; n < N_IRQ; n++) begin : g_line
        localparam int W  = n / 32;
        localparam int B  = n % 32;
        localparam int R  = n / 4;
        localparam int LO = 8 * (n % 4) + LANE_LO;

        logic                 en_bit;
        logic [PRIO_BITS-1:0] pr_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_bit <= 1'b0;
            end else if (bus_we && set_hit[W] && bus_wdata[B]) begin
                en_bit <= 1'b1;
            end else if (bus_we && clr_hit[W] && bus_wdata[B]) begin
                en_bit <= 1'b0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pr_q <= '0;
            end else if (bus_we && prio_hit[R]) begin
                pr_q <= bus_wdata[LO +: PRIO_BITS];
            end
        end

        assign en_vec[n] = en_bit;
        assign prio_flat[n*PRIO_BITS +: PRIO_BITS] = pr_q;
    end

    // Read path: padded images of the enable and priority state.
    always_comb begin
        en_pad   = '0;
        prio_pad = '0;
        en_pad[N_IRQ-1:0] = en_vec;
        for (int n = 0; n < N_IRQ; n++) begin
            prio_pad[8*n + LANE_LO +: PRIO_BITS] = prio_flat[n*PRIO_BITS +: PRIO_BITS];
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < N_EN_WORDS; k++) begin
            if (set_hit[k] || clr_hit[k]) begin
                bus_rdata = en_pad[32*k +: 32];
            end
        end
        for (int j = 0; j < N_PRIO_REGS; j++) begin
            if (prio_hit[j]) begin
                bus_rdata = prio_pad[32*j +: 32];
            end
        end
    end

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
    parameter int N_IRQ     = 96,
    parameter int PRIO_BITS = 4,
    parameter int ID_W      = $clog2(N_IRQ)
) (
    input  logic [N_IRQ-1:0]           req_vec,
    input  logic [N_IRQ*PRIO_BITS-1:0] prio_flat,
    output logic                       found,
    output logic [ID_W-1:0]            win_id,
    output logic [PRIO_BITS-1:0]       win_prio
);

    // Strict less-than keeps the lower number on a tie.
    always_comb begin
        found    = 1'b0;
        win_id   = '0;
        win_prio = '1;
        for (int n = 0; n < N_IRQ; n++) begin
            if (req_vec[n] &&
                (!found || (prio_flat[n*PRIO_BITS +: PRIO_BITS] < win_prio))) begin
                found    = 1'b1;
                win_id   = ID_W'(n);
                win_prio = prio_flat[n*PRIO_BITS +: PRIO_BITS];
            end
        end
    end

endmodule

// File: rtl/intc_nest.sv
module intc_nest #(
    parameter int PRIO_BITS = 4,
    parameter int DEPTH     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push,
    input  logic [PRIO_BITS-1:0] push_prio,
    input  logic                 pop,
    output logic [PRIO_BITS:0]   cur_lvl,
    output logic                 is_idle,
    output logic                 is_full
);
    import intc_pkg::*;

    localparam int LVL_W = PRIO_BITS + 1;
    localparam int PTR_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [LVL_W-1:0] IDLE_LVL = LVL_W'(2 ** PRIO_BITS);

    nest_state_e          state_q, state_d;
    logic [PTR_W-1:0]     ptr_q;
    logic [LVL_W-1:0]     lvl_q;
    logic [LVL_W-1:0]     stk [DEPTH];
    logic                 do_push, do_pop;
    logic [IDX_W-1:0]     wr_idx, rd_idx;

    assign do_push = push && (state_q != ST_FULL);
    assign do_pop  = pop && !push && (state_q != ST_IDLE);
    assign wr_idx  = IDX_W'(ptr_q);
    assign rd_idx  = IDX_W'(ptr_q - PTR_W'(1));

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (do_push) begin
                    state_d = (DEPTH == 1) ? ST_FULL : ST_NESTED;
                end
            end
            ST_NESTED: begin
                if (do_push && (ptr_q == PTR_W'(DEPTH - 1))) begin
                    state_d = ST_FULL;
                end else if (do_pop && (ptr_q == PTR_W'(1))) begin
                    state_d = ST_IDLE;
                end
            end
            ST_FULL: begin
                if (do_pop) begin
                    state_d = (DEPTH == 1) ? ST_IDLE : ST_NESTED;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Stack and running level.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            lvl_q <= IDLE_LVL;
        end else if (do_push) begin
            stk[wr_idx] <= lvl_q;
            ptr_q       <= ptr_q + PTR_W'(1);
            lvl_q       <= {1'b0, push_prio};
        end else if (do_pop) begin
            ptr_q <= ptr_q - PTR_W'(1);
            lvl_q <= stk[rd_idx];
        end
    end

    // Outputs.
    always_comb begin
        cur_lvl = lvl_q;
        is_idle = (state_q == ST_IDLE);
        is_full = (state_q == ST_FULL);
    end

endmodule

// File: rtl/prio_intc.sv
module prio_intc #(
    parameter int N_IRQ     = 96,
    parameter int PRIO_BITS = 4,
    parameter int DEPTH     = 16,
    parameter int ADDR_W    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_IRQ-1:0]     irq_in,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    input  logic                 bus_we,
    output logic [31:0]          bus_rdata,
    output logic                 irq_req,
    output logic [$clog2(N_IRQ)-1:0] irq_id,
    output logic [PRIO_BITS-1:0] irq_prio,
    output logic [PRIO_BITS:0]   active_level,
    input  logic                 irq_ack,
    input  logic                 irq_done
);

    localparam int ID_W = $clog2(N_IRQ);

    logic [N_IRQ-1:0]           en_vec;
    logic [N_IRQ*PRIO_BITS-1:0] prio_flat;
    logic [N_IRQ-1:0]           pend_q;
    logic [N_IRQ-1:0]           ack_mask;
    logic                       found;
    logic [ID_W-1:0]            win_id;
    logic [PRIO_BITS-1:0]       win_prio;
    logic                       ack_ok;
    logic                       nest_idle;
    logic                       nest_full;

    intc_regs #(
        .N_IRQ(N_IRQ), .PRIO_BITS(PRIO_BITS), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_rdata(bus_rdata), .en_vec(en_vec), .prio_flat(prio_flat)
    );

    intc_arbiter #(
        .N_IRQ(N_IRQ), .PRIO_BITS(PRIO_BITS), .ID_W(ID_W)
    ) u_arb (
        .req_vec(pend_q & en_vec), .prio_flat(prio_flat),
        .found(found), .win_id(win_id), .win_prio(win_prio)
    );

    intc_nest #(
        .PRIO_BITS(PRIO_BITS), .DEPTH(DEPTH)
    ) u_nest (
        .clk(clk), .rst_n(rst_n),
        .push(ack_ok), .push_prio(win_prio), .pop(irq_done),
        .cur_lvl(active_level), .is_idle(nest_idle), .is_full(nest_full)
    );

    assign irq_req  = found && ({1'b0, win_prio} < active_level) && !nest_full;
    assign irq_id   = win_id;
    assign irq_prio = win_prio;
    assign ack_ok   = irq_ack && irq_req;

    always_comb begin
        ack_mask = '0;
        if (ack_ok) begin
            ack_mask[win_id] = 1'b1;
        end
    end

    // Pending latch: set by a high line, cleared on acknowledge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q | irq_in) & ~ack_mask;
        end
    end

endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
    parameter int PRIO_BITS = 4,
    parameter int ID_W      = 7,
    parameter int ADDR_W    = 12,
    parameter int N_IRQ     = 96
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [31:0]          bus_rdata,
    input logic                 irq_req,
    input logic [ID_W-1:0]      irq_id,
    input logic [PRIO_BITS-1:0] irq_prio,
    input logic [PRIO_BITS:0]   active_level,
    input logic                 irq_ack,
    input logic                 irq_done,
    input logic                 nest_idle
);
    localparam logic [PRIO_BITS:0] IDLE_LVL = (PRIO_BITS+1)'(2 ** PRIO_BITS);
    localparam logic [7:0]  LOW_LANE = 8'((1 << (8 - PRIO_BITS)) - 1);
    localparam logic [31:0] LOW_MASK = {4{LOW_LANE}};
    localparam int PRIO_END = 32'h400 + 4 * ((N_IRQ + 3) / 4);

    logic in_prio;
    assign in_prio = (int'(bus_addr) >= 32'h400) && (int'(bus_addr) < PRIO_END)
                     && (bus_addr[1:0] == 2'b00);

    // R4: low bits of every priority lane read as zero
    p_prio_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_prio |-> ((bus_rdata & LOW_MASK) == 32'd0));

    // R7: accepted acknowledge moves the running level to the offered priority
    p_ack_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req) |=> (active_level == {1'b0, $past(irq_prio)}));

    // R9: completion while running returns to a less urgent level
    p_done_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_done && !irq_ack && !nest_idle) |=> (active_level > $past(active_level)));

    // R9: completion while idle changes nothing
    p_idle_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_done && !irq_ack && nest_idle) |=> (active_level == IDLE_LVL));

    // R10: idle state and idle level agree
    p_idle_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        nest_idle == (active_level == IDLE_LVL));

    // R5: an offer is always more urgent than the running level
    p_req_urgent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |-> ({1'b0, irq_prio} < active_level));

endmodule

bind prio_intc intc_checker #(
    .PRIO_BITS(PRIO_BITS), .ID_W(ID_W), .ADDR_W(ADDR_W), .N_IRQ(N_IRQ)
) u_intc_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .irq_id(irq_id), .irq_prio(irq_prio),
    .active_level(active_level), .irq_ack(irq_ack), .irq_done(irq_done),
    .nest_idle(nest_idle)
);

// File: tb/prio_intc_bench.sv
module prio_intc_bench;

    localparam int N = 96;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] irq_in = '0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq_req;
    logic [6:0]  irq_id;
    logic [3:0]  irq_prio;
    logic [4:0]  active_level;
    logic        irq_ack = 1'b0;
    logic        irq_done = 1'b0;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int bp [N];

    prio_intc u_prio_intc (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_rdata(bus_rdata), .irq_req(irq_req), .irq_id(irq_id),
        .irq_prio(irq_prio), .active_level(active_level),
        .irq_ack(irq_ack), .irq_done(irq_done)
    );

    always #5 clk = ~clk;

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] d);
        @(negedge clk);
        bus_addr = 12'(addr); bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] d);
        @(negedge clk);
        bus_addr = 12'(addr);
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input logic [N-1:0] m);
        @(negedge clk); irq_in = m;
        @(negedge clk); irq_in = '0;
    endtask

    task automatic ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic done();
        @(negedge clk); irq_done = 1'b1;
        @(negedge clk); irq_done = 1'b0;
    endtask

    task automatic load_prio();
        for (int j = 0; j < N / 4; j++) begin
            logic [31:0] w;
            w = '0;
            for (int l = 0; l < 4; l++) w[8*l+4 +: 4] = 4'(bp[4*j+l]);
            wr(32'h400 + 4*j, w);
        end
    endtask

    initial begin
        logic [31:0] d;
        logic [N-1:0] rem;
        logic [N-1:0] one;
        int best;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        chk(irq_req == 1'b0, "R10 req", irq_req, 0);
        chk(active_level == 5'd16, "R10 level", active_level, 16);
        rd(32'h104, d); chk(d == 0, "R10 enable", d, 0);
        rd(32'h410, d); chk(d == 0, "R10 prio", d, 0);

        // R4: every priority lane, low nibble ignored
        for (int j = 0; j < N / 4; j++) begin
            logic [31:0] w, e;
            for (int l = 0; l < 4; l++) begin
                w[8*l +: 8] = {4'((4*j + l) % 16), 4'hF};
                e[8*l +: 8] = {4'((4*j + l) % 16), 4'h0};
            end
            wr(32'h400 + 4*j, w);
            rd(32'h400 + 4*j, d);
            chk(d == e, "R4 prio lane", d, e);
        end

        // R2/R3: every enable bit alone, zeros ignored
        wr(32'h100, 32'h0);
        rd(32'h180, d); chk(d == 0, "R2 zero write", d, 0);
        for (int n = 0; n < N; n++) begin
            logic [31:0] b;
            b = 32'h1 << (n % 32);
            wr(32'h100 + 4*(n/32), b);
            wr(32'h180 + 4*(n/32), 32'h0);
            rd(32'h180 + 4*(n/32), d); chk(d == b, "R2 set bit", d, b);
            wr(32'h180 + 4*(n/32), b);
            rd(32'h100 + 4*(n/32), d); chk(d == 0, "R3 clear bit", d, 0);
        end

        // R11: unmapped space
        wr(32'h200, 32'hFFFF_FFFF);
        rd(32'h200, d); chk(d == 0, "R11 unmapped", d, 0);
        rd(32'h10C, d); chk(d == 0, "R11 beyond bank", d, 0);
        rd(32'h100, d); chk(d == 0, "R11 no side effect", d, 0);

        // R5/R1/R7/R9: arbitration sweep over tie-rich priorities
        for (int n = 0; n < N; n++) bp[n] = (n * 5 + 3) % 16;
        load_prio();
        for (int k = 0; k < 3; k++) wr(32'h100 + 4*k, 32'hFFFF_FFFF);
        for (int t = 1; t <= 6; t++) begin
            rem = '0;
            for (int n = 0; n < N; n++) rem[n] = (((n * t + t * t) % 7) == 0);
            pulse(rem);
            while (rem != '0) begin
                best = -1;
                for (int n = 0; n < N; n++)
                    if (rem[n] && (best < 0 || bp[n] < bp[best])) best = n;
                #1;
                chk(irq_req == 1'b1, "R1 pending offered", irq_req, 1);
                chk(irq_id == 7'(best), "R5 winner id", irq_id, best);
                ack();
                #1 chk(active_level == 5'(bp[best]), "R7 level after ack", active_level, bp[best]);
                done();
                #1 chk(active_level == 5'd16, "R9 level after done", active_level, 16);
                rem[best] = 1'b0;
            end
            #1 chk(irq_req == 1'b0, "R1 cleared by ack", irq_req, 0);
        end

        // R6: disabled pending is held
        wr(32'h180, 32'h20);
        one = '0; one[5] = 1'b1;
        pulse(one);
        #1 chk(irq_req == 1'b0, "R6 disabled held", irq_req, 0);
        wr(32'h100, 32'h20);
        #1 chk(irq_req && irq_id == 7'd5, "R6 offered once enabled", irq_id, 5);
        ack(); done();

        // R8: preemption
        bp[10] = 8; bp[11] = 8; bp[12] = 3;
        load_prio();
        one = '0; one[10] = 1'b1; pulse(one); ack();
        #1 chk(active_level == 5'd8, "R8 running 10", active_level, 8);
        one = '0; one[11] = 1'b1; pulse(one);
        #1 chk(irq_req == 1'b0, "R8 equal held", irq_req, 0);
        one = '0; one[12] = 1'b1; pulse(one);
        #1 chk(irq_req && irq_id == 7'd12, "R8 urgent preempts", irq_id, 12);
        ack();
        #1 chk(active_level == 5'd3, "R8 nested level", active_level, 3);
        done();
        #1 chk(active_level == 5'd8, "R9 restore 8", active_level, 8);
        chk(irq_req == 1'b0, "R8 equal still held", irq_req, 0);
        done();
        #1 chk(irq_req && irq_id == 7'd11, "R8 held one offered", irq_id, 11);
        ack(); done();
        #1 chk(active_level == 5'd16, "R9 back to idle", active_level, 16);

        // R9: completion while idle, and coincident ack/done
        done();
        #1 chk(active_level == 5'd16, "R9 idle done", active_level, 16);
        one = '0; one[20] = 1'b1; pulse(one);
        @(negedge clk); irq_ack = 1'b1; irq_done = 1'b1;
        @(negedge clk); irq_ack = 1'b0; irq_done = 1'b0;
        #1 chk(active_level == 5'(bp[20]), "R9 ack wins", active_level, bp[20]);
        done();

        // R11: 16-deep nest, unwound level by level
        for (int i = 0; i < 16; i++) bp[i] = 15 - i;
        load_prio();
        for (int i = 0; i < 16; i++) begin
            one = '0; one[i] = 1'b1; pulse(one);
            #1 chk(irq_req && irq_id == 7'(i), "R11 nest offer", irq_id, i);
            ack();
        end
        #1 chk(active_level == 5'd0, "R11 deepest", active_level, 0);
        for (int i = 15; i >= 0; i--) begin
            done();
            #1 chk(active_level == 5'(16 - i), "R11 unwind", active_level, 16 - i);
        end

        finish_run();
    end

endmodule